// File: doc/BRIEF.md
# Clock and Supply Status-Change Interrupt Unit

This block watches three health conditions of a chip's clocking and supply: whether the PLL reports lock, whether the crystal oscillator is considered up, and whether the analog supply is low. Each condition is kept as a status bit. Any change of a status bit, in either direction, sets a sticky flag for that source. Software clears a flag by writing a 1 to it. A per-source enable decides whether a set flag drives the single combined interrupt output.

Two of the status bits are produced by small state machines. The oscillator state machine has three states. `OSC_OFF` is left for `OSC_WAIT_LOCK` once the oscillator is enabled and full stop mode is not active. `OSC_WAIT_LOCK` is left for `OSC_RUNNING` when the lock status is 1 and no PLL reconfiguration pulse is present. `OSC_RUNNING` returns to `OSC_WAIT_LOCK` on loss of lock or on a reconfiguration pulse. From any state, a disabled oscillator or full stop mode forces `OSC_OFF`. Only `OSC_RUNNING` reports the oscillator as up. The supply state machine moves from `LV_NORMAL` to `LV_LOW` when the below-assert comparator is high. It moves from `LV_LOW` back to `LV_NORMAL` only when the above-release comparator is high. In all other cases it holds its state, which gives hysteresis.

Software reaches the block through a small synchronous register port. The port has a write strobe, a 2-bit address, write data and combinational read data.

Top module: `clkstat_irq_unit`

## Requirements
- R1: The lock status (read address 0, bit 0) equals the raw lock input sampled at the previous clock edge. A PLL reconfiguration pulse present at that edge forces it to 0.
- R2: The lock flag (address 1, bit 0) is set one clock after the lock status changes, both on a rise and on a fall.
- R3: A write to address 1 clears each flag whose data bit is 1. Flags written with 0 are unchanged. If a status change arrives at the same edge as the clear, the flag stays set.
- R4: While the oscillator enable is 0, the oscillator-up status (address 0, bit 1) is 0 from the next clock on.
- R5: The oscillator-up status rises only after the lock status was 1 at the previous edge. Enabling the oscillator with no lock leaves it at 0.
- R6: Loss of lock status, a PLL reconfiguration pulse or full stop mode forces the oscillator-up status to 0 at the next clock.
- R7: The oscillator flag (address 1, bit 1) is set one clock after any change of the oscillator-up status.
- R8: The low-voltage status (address 0, bit 2) becomes 1 when the below-assert input is high. It becomes 0 only when the above-release input is high. It holds while both inputs are low.
- R9: The low-voltage flag (address 1, bit 2) is set one clock after any change of the low-voltage status.
- R10: The interrupt output is high exactly when some flag is set and its enable bit is 1. A masked flag stays set but does not drive the output.
- R11: Address 2 holds the read/write enables at bit 0 (lock), bit 1 (oscillator) and bit 2 (low voltage). Address 3 and all unused upper bits read 0.
- R12: After reset, all status bits, flags, enables and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_raw | input | 1 | Raw lock indication from the PLL |
| pll_reconfig | input | 1 | One-cycle pulse when PLL settings change |
| osc_enable | input | 1 | Oscillator enable |
| full_stop | input | 1 | Full stop mode active |
| vdd_below_assert | input | 1 | Supply comparator: below the assert level |
| vdd_above_release | input | 1 | Supply comparator: above the release level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
Some rules can be checked on every cycle, and the assertions do so. They check the following:
- the lock status follows the raw lock input;
- the oscillator-up status drops on a disabled oscillator, loss of lock, reconfiguration or full stop;
- a rise of oscillator-up is preceded by lock;
- the supply status obeys the comparator that is active;
- each status change sets its flag;
- a clear write with no competing change empties the flag;
- an enabled flag drives the interrupt.

Other behaviour only shows up in sequences of events, so only the bench's scenarios can demonstrate it. This covers holding between the two supply thresholds over many cycles, the change-wins-over-clear collision, the two-cycle climb from `OSC_OFF` through `OSC_WAIT_LOCK` to `OSC_RUNNING`, masking, and the register layout.

// File: rtl/clkstat_pkg.sv
`timescale 1ns/1ps
package clkstat_pkg;
    localparam int NSRC     = 3;
    localparam int SRC_LOCK = 0;
    localparam int SRC_OSC  = 1;
    localparam int SRC_LV   = 2;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] A_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 2'd1;
    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd2;

    typedef enum logic [1:0] {
        OSC_OFF       = 2'd0,
        OSC_WAIT_LOCK = 2'd1,
        OSC_RUNNING   = 2'd2
    } osc_state_t;

    typedef enum logic {
        LV_NORMAL = 1'b0,
        LV_LOW    = 1'b1
    } lv_state_t;
endpackage

// File: rtl/clkstat_lock_track.sv
`timescale 1ns/1ps
module clkstat_lock_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pll_lock_raw,
    input  logic pll_reconfig,
    output logic lock_st
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_st <= 1'b0;
        end else begin
            lock_st <= pll_lock_raw & ~pll_reconfig;
        end
    end
endmodule

// File: rtl/clkstat_osc_fsm.sv
`timescale 1ns/1ps
module clkstat_osc_fsm
    import clkstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_enable,
    input  logic full_stop,
    input  logic lock_st,
    input  logic pll_reconfig,
    output logic osc_up
);
    osc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!osc_enable || full_stop) begin
            state_d = OSC_OFF;
        end else begin
            unique case (state_q)
                OSC_OFF:       state_d = OSC_WAIT_LOCK;
                OSC_WAIT_LOCK: if (lock_st && !pll_reconfig) state_d = OSC_RUNNING;
                OSC_RUNNING:   if (!lock_st || pll_reconfig) state_d = OSC_WAIT_LOCK;
                default:       state_d = OSC_OFF;
            endcase
        end
    end

    always_comb begin
        osc_up = (state_q == OSC_RUNNING);
    end
endmodule

// File: rtl/clkstat_lv_fsm.sv
`timescale 1ns/1ps
module clkstat_lv_fsm
    import clkstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_below_assert,
    input  logic vdd_above_release,
    output logic lv_st
);
    lv_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_NORMAL: if (vdd_below_assert)  state_d = LV_LOW;
            LV_LOW:    if (vdd_above_release) state_d = LV_NORMAL;
            default:   state_d = LV_NORMAL;
        endcase
    end

    always_comb begin
        lv_st = (state_q == LV_LOW);
    end
endmodule

// File: rtl/clkstat_flag_bank.sv
`timescale 1ns/1ps
module clkstat_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic prev_q;
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                prev_q <= status[i];
                flag_q <= (flag_q & ~clr[i]) | (status[i] ^ prev_q);
            end
        end
        assign flags[i] = flag_q;
    end

    always_comb begin
        irq = |(flags & en);
    end
endmodule

// File: rtl/clkstat_irq_unit.sv
`timescale 1ns/1ps
module clkstat_irq_unit
    import clkstat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_lock_raw,
    input  logic          pll_reconfig,
    input  logic          osc_enable,
    input  logic          full_stop,
    input  logic          vdd_below_assert,
    input  logic          vdd_above_release,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    logic            lock_st, osc_up, lv_st;
    logic [NSRC-1:0] status, flags, flag_clr, irq_en;
    logic            unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DW-1:NSRC];

    clkstat_lock_track u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_lock_raw (pll_lock_raw),
        .pll_reconfig (pll_reconfig),
        .lock_st      (lock_st)
    );

    clkstat_osc_fsm u_osc (
        .clk          (clk),
        .rst_n        (rst_n),
        .osc_enable   (osc_enable),
        .full_stop    (full_stop),
        .lock_st      (lock_st),
        .pll_reconfig (pll_reconfig),
        .osc_up       (osc_up)
    );

    clkstat_lv_fsm u_lv (
        .clk               (clk),
        .rst_n             (rst_n),
        .vdd_below_assert  (vdd_below_assert),
        .vdd_above_release (vdd_above_release),
        .lv_st             (lv_st)
    );

    always_comb begin
        status           = '0;
        status[SRC_LOCK] = lock_st;
        status[SRC_OSC]  = osc_up;
        status[SRC_LV]   = lv_st;
        flag_clr         = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[NSRC-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en <= '0;
        end else if (reg_wr && reg_addr == A_ENABLE) begin
            irq_en <= reg_wdata[NSRC-1:0];
        end
    end

    clkstat_flag_bank #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .clr    (flag_clr),
        .en     (irq_en),
        .flags  (flags),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STATUS: reg_rdata[NSRC-1:0] = status;
            A_FLAGS:  reg_rdata[NSRC-1:0] = flags;
            A_ENABLE: reg_rdata[NSRC-1:0] = irq_en;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkstat_irq_unit_chk.sv
`timescale 1ns/1ps
module clkstat_irq_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_lock_raw,
    input logic       pll_reconfig,
    input logic       osc_enable,
    input logic       full_stop,
    input logic       vdd_below_assert,
    input logic       vdd_above_release,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       lock_st,
    input logic       osc_up,
    input logic       lv_st,
    input logic [2:0] flags,
    input logic [2:0] irq_en
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_lock_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (lock_st == $past(pll_lock_raw && !pll_reconfig)));

    p_lock_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lock_st != $past(lock_st)) |=> flags[0]);

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && reg_wr && reg_addr == 2'd1 && reg_wdata[0] && lock_st == $past(lock_st))
        |=> !flags[0]);

    p_osc_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_enable |=> !osc_up);

    p_osc_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(osc_up)) |-> $past(lock_st));

    p_osc_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_st || pll_reconfig || full_stop) |=> !osc_up);

    p_osc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && osc_up != $past(osc_up)) |=> flags[1]);

    p_lv_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_below_assert && !vdd_above_release) |=> lv_st);

    p_lv_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_above_release && !vdd_below_assert) |=> !lv_st);

    p_lv_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vdd_above_release && !vdd_below_assert && past_ok) |=> (lv_st == $past(lv_st)));

    p_lv_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lv_st != $past(lv_st)) |=> flags[2]);

    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(flags & irq_en)) && !reg_wr) |=> irq);
endmodule

bind clkstat_irq_unit clkstat_irq_unit_chk u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .pll_lock_raw      (pll_lock_raw),
    .pll_reconfig      (pll_reconfig),
    .osc_enable        (osc_enable),
    .full_stop         (full_stop),
    .vdd_below_assert  (vdd_below_assert),
    .vdd_above_release (vdd_above_release),
    .reg_wr            (reg_wr),
    .reg_addr          (reg_addr),
    .reg_wdata         (reg_wdata),
    .irq               (irq),
    .lock_st           (lock_st),
    .osc_up            (osc_up),
    .lv_st             (lv_st),
    .flags             (flags),
    .irq_en            (irq_en)
);

// File: tb/clkstat_irq_unit_test.sv
`timescale 1ns/1ps
module clkstat_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_lock_raw = 1'b0, pll_reconfig = 1'b0;
    logic       osc_enable = 1'b0, full_stop = 1'b0;
    logic       vdd_below_assert = 1'b0, vdd_above_release = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clkstat_irq_unit uut (
        .clk (clk), .rst_n (rst_n),
        .pll_lock_raw (pll_lock_raw), .pll_reconfig (pll_reconfig),
        .osc_enable (osc_enable), .full_stop (full_stop),
        .vdd_below_assert (vdd_below_assert), .vdd_above_release (vdd_above_release),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .irq (irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'd0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(2'd0, v); check("R12", "status after reset", v, 8'h00);
        rd_reg(2'd1, v); check("R12", "flags after reset", v, 8'h00);
        rd_reg(2'd2, v); check("R12", "enables after reset", v, 8'h00);
        check("R12", "irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, v); check("R11", "enable readback", v, 8'h07);
        pll_lock_raw = 1'b1;
        step(1);
        rd_reg(2'd0, v); check("R1", "lock status one clock later", v, 8'h01);
        rd_reg(2'd1, v); check("R2", "flag not yet set", v, 8'h00);
        step(1);
        rd_reg(2'd1, v); check("R2", "lock flag on rise", v, 8'h01);
        check("R10", "irq with enabled flag", {7'd0, irq}, 8'h01);
        rd_reg(2'd0, v); check("R4", "osc stays down while disabled", v, 8'h01);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd1, v); check("R3", "write 0 keeps flag", v, 8'h01);
        wr_reg(2'd1, 8'h01);
        rd_reg(2'd1, v); check("R3", "write 1 clears flag", v, 8'h00);
        pll_lock_raw = 1'b0;
        step(2);
        rd_reg(2'd1, v); check("R2", "lock flag on fall", v, 8'h01);
        wr_reg(2'd1, 8'h01);
        pll_lock_raw = 1'b1;
        step(1);
        wr_reg(2'd1, 8'h01);
        rd_reg(2'd1, v); check("R3", "change wins over same-edge clear", v, 8'h01);
        wr_reg(2'd1, 8'h07);
        rd_reg(2'd1, v); check("R3", "flags cleared", v, 8'h00);
        pll_lock_raw = 1'b0;
        step(2);
        wr_reg(2'd1, 8'h07);
    endtask

    task automatic t_osc;
        logic [7:0] v;
        osc_enable = 1'b1;
        step(5);
        rd_reg(2'd0, v); check("R5", "osc down without lock", v, 8'h00);
        pll_lock_raw = 1'b1;
        step(1);
        rd_reg(2'd0, v); check("R5", "osc waits one clock after lock", v, 8'h01);
        step(1);
        rd_reg(2'd0, v); check("R5", "osc up after lock", v, 8'h03);
        step(1);
        rd_reg(2'd1, v); check("R7", "osc flag on rise", v, 8'h03);
        wr_reg(2'd1, 8'h07);
        pll_reconfig = 1'b1;
        step(1);
        pll_reconfig = 1'b0;
        rd_reg(2'd0, v); check("R6", "reconfig drops lock and osc", v, 8'h00);
        step(2);
        rd_reg(2'd0, v); check("R6", "osc recovers after relock", v, 8'h03);
        rd_reg(2'd1, v); check("R7", "flags after reconfig cycle", v, 8'h03);
        wr_reg(2'd1, 8'h07);
        full_stop = 1'b1;
        step(1);
        rd_reg(2'd0, v); check("R6", "full stop drops osc", v, 8'h01);
        full_stop = 1'b0;
        step(2);
        rd_reg(2'd0, v); check("R6", "osc back after full stop", v, 8'h03);
        osc_enable = 1'b0;
        step(1);
        rd_reg(2'd0, v); check("R4", "osc down once disabled", v, 8'h01);
        step(4);
        rd_reg(2'd0, v); check("R4", "osc stays down though locked", v, 8'h01);
        rd_reg(2'd1, v); check("R7", "osc flag from disable", v, 8'h02);
        wr_reg(2'd1, 8'h07);
    endtask

    task automatic t_lv;
        logic [7:0] v;
        vdd_below_assert = 1'b1;
        step(1);
        rd_reg(2'd0, v); check("R8", "low status set", v, 8'h05);
        step(1);
        rd_reg(2'd1, v); check("R9", "lv flag on set", v, 8'h04);
        wr_reg(2'd1, 8'h04);
        vdd_below_assert = 1'b0;
        step(6);
        rd_reg(2'd0, v); check("R8", "low status holds between levels", v, 8'h05);
        rd_reg(2'd1, v); check("R9", "no flag while holding", v, 8'h00);
        vdd_above_release = 1'b1;
        step(1);
        rd_reg(2'd0, v); check("R8", "low status released", v, 8'h01);
        vdd_above_release = 1'b0;
        step(4);
        rd_reg(2'd0, v); check("R8", "normal status holds", v, 8'h01);
        rd_reg(2'd1, v); check("R9", "lv flag on release", v, 8'h04);
        wr_reg(2'd1, 8'h07);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr_reg(2'd2, 8'h06);
        pll_lock_raw = 1'b0;
        step(2);
        rd_reg(2'd1, v); check("R10", "masked flag still set", v, 8'h01);
        check("R10", "masked flag gives no irq", {7'd0, irq}, 8'h00);
        wr_reg(2'd2, 8'h01);
        check("R10", "irq after unmask", {7'd0, irq}, 8'h01);
        rd_reg(2'd3, v); check("R11", "address 3 reads zero", v, 8'h00);
        wr_reg(2'd1, 8'h01);
        check("R10", "irq drops after clear", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_lock();
        t_osc();
        t_lv();
        t_mask();
        step(2);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule